// File: doc/BRIEF.md
# Auxiliary-Channel Request Framer and Reply Classifier

This block covers one transaction on a display auxiliary channel and stays above the line code. On a start strobe it captures a 4-bit command, a 20-bit address, a length of 0 to 16 and up to 16 write bytes. From these it builds the ordered byte image that the serializer must send, and it reports how many of those bytes are meaningful. It then holds that request until the receive path reports that a reply is complete.

When the reply is complete, the block takes in the receiver's error flags, the received byte count, the upper nibble of the first received byte and the bytes after it. It sorts the outcome into one result code and presents the sink's reply code, the data byte count and the data bytes. A one-cycle done pulse marks the moment these outputs are valid. A controller above the block decides what to do next: retry, defer or give up.

Top module: `aux_xact_engine`

## Requirements
- R1: The first three frame bytes hold `{cmd, addr[19:16]}` in byte 0, `addr[15:8]` in byte 1 and `addr[7:0]` in byte 2. Byte k appears on `tx_bytes[8k+7:8k]`.
- R2: A request with nonzero length carries byte 3 equal to length minus one. `tx_count` is 3 for length 0 and 4 otherwise, and write commands add the length to it.
- R3: Only the commands 4'h8, 4'h0 and 4'h4 count as writes. For these, the payload bytes follow the header from byte 4 on, in order. Every frame byte at or beyond `tx_count` reads zero.
- R4: While a request waits for its reply (`busy` high), a start strobe is ignored. The frame, `tx_count` and `busy` do not change, and no done pulse results.
- R5: The frame and `busy` appear one cycle after the start strobe is sampled. `done` is high for exactly one cycle, one cycle after `rx_done` is sampled while busy, and `busy` drops at the same time.
- R6: A hot-plug loss flag gives result 1 (lost link), whatever other flags are set.
- R7: Without hot-plug loss, either timeout flag gives result 2 (timeout), ahead of the framing flags.
- R8: Otherwise, any of the four framing flags (bad stop, no detect, bad high, bad low) gives result 3 (invalid reply). A clean reply with a received count of zero also gives result 3.
- R9: A clean reply with a nonzero count gives result 0. `reply_code` is the upper nibble of the first received byte, and `ret_count` is the received count minus one.
- R10: Data bytes appear on `rd_data` only for result 0 with reply code 0 (ACK). Byte j holds the j-th byte after the status byte, for j below `ret_count`. All other `rd_data` bytes read zero.
- R11: An ACK whose received count minus one exceeds the requested length gives result 4 (overrun). In that case `ret_count` is 0, `rd_data` is zero and `reply_code` is still reported.
- R12: After reset, `busy`, `done`, `tx_count`, `tx_bytes`, `result`, `reply_code`, `ret_count` and `rd_data` are all zero.
- R13: An `rx_done` pulse while not busy is ignored. No done pulse follows and the reply outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled only when not busy |
| cmd | input | 4 | Request command nibble |
| addr | input | 20 | Request address |
| req_len | input | 5 | Requested byte count, 0 to 16 |
| wr_data | input | 128 | Write payload, byte j on bits 8j+7:8j |
| rx_done | input | 1 | Reply complete strobe from the receiver |
| rx_count | input | 5 | Bytes received including the status byte |
| rx_code | input | 4 | Upper nibble of the first received byte |
| rx_data | input | 128 | Received bytes after the status byte, byte j on bits 8j+7:8j |
| rx_hpd_lost | input | 1 | Hot-plug disconnect seen |
| rx_tmo | input | 1 | Receive timeout |
| rx_tmo_state | input | 1 | Receive timeout state machine flag |
| rx_bad_stop | input | 1 | Invalid stop condition |
| rx_no_detect | input | 1 | Reply not detected |
| rx_bad_high | input | 1 | Invalid high symbol |
| rx_bad_low | input | 1 | Invalid low symbol |
| busy | output | 1 | Request framed and awaiting its reply |
| tx_count | output | 5 | Number of meaningful frame bytes |
| tx_bytes | output | 160 | Frame image, byte k on bits 8k+7:8k |
| done | output | 1 | One-cycle pulse, reply outputs valid |
| result | output | 3 | 0 ok, 1 lost link, 2 timeout, 3 invalid reply, 4 overrun |
| reply_code | output | 4 | Sink reply code |
| ret_count | output | 5 | Returned data byte count |
| rd_data | output | 128 | Returned data bytes |

## Verification
The frame outputs and `busy` pass through a single register. They are due one edge after the start strobe, so the bench drives start on a falling edge and checks the frame on the next falling edge. The classification also passes through one register. The bench therefore checks `done` and the reply outputs on the falling edge after the one where `rx_done` was driven, and then confirms that `done` is low one cycle later. The start-while-busy and reply-while-idle pokes are checked on the falling edge one cycle later, and they are held against values the bench saved before the poke.

// File: rtl/aux_xact_pkg.sv
// Shared types for the auxiliary-channel transaction engine.
package aux_xact_pkg;

    // Outcome of one reply, in priority order of the checks that produce it.
    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_HPD     = 3'd1,
        RES_TIMEOUT = 3'd2,
        RES_INVALID = 3'd3,
        RES_OVERRUN = 3'd4
    } aux_result_e;

    // Error flags reported by the receive path.
    typedef struct packed {
        logic hpd_lost;
        logic tmo;
        logic tmo_state;
        logic bad_stop;
        logic no_detect;
        logic bad_high;
        logic bad_low;
    } aux_rx_flags_t;

    // Commands that carry a payload: native write, I2C write, I2C write continuing.
    function automatic logic cmd_is_write(input logic [3:0] c);
        return (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
    endfunction

endpackage

// File: rtl/aux_req_framer.sv
// Request framer: combinational image of one request.
// Assumes len <= MAX_LEN. Bytes at or beyond the returned count are zero.
module aux_req_framer
    import aux_xact_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int CNT_W   = 5,
    parameter int TX_MAX  = MAX_LEN + 4
) (
    input  logic [3:0]            cmd,
    input  logic [19:0]           addr,
    input  logic [LEN_W-1:0]      len,
    input  logic [MAX_LEN*8-1:0]  wr_data,
    output logic [TX_MAX*8-1:0]   frame,
    output logic [CNT_W-1:0]      count
);

    logic is_wr;
    logic has_len;

    // Classify the command and the length.
    always_comb begin
        is_wr   = cmd_is_write(cmd);
        has_len = (len != '0);
    end

    // Header: command with the top address nibble, then the address middle and low bytes.
    assign frame[7:0]   = {cmd, addr[19:16]};
    assign frame[15:8]  = addr[15:8];
    assign frame[23:16] = addr[7:0];
    // Length byte, present only for a nonzero length.
    assign frame[31:24] = has_len ? (8'(len) - 8'd1) : 8'h00;

    // Payload bytes, present only for writes and only below the length.
    for (genvar p = 0; p < MAX_LEN; p++) begin : g_pay
        assign frame[(4+p)*8 +: 8] = (is_wr && (LEN_W'(p) < len)) ? wr_data[p*8 +: 8] : 8'h00;
    end

    // Meaningful byte count: header, optional length byte, write payload.
    always_comb begin
        count = has_len ? CNT_W'(4) : CNT_W'(3);
        if (is_wr)
            count = count + CNT_W'(len);
    end

endmodule

// File: rtl/aux_rpl_classifier.sv
// Reply classifier: combinational outcome of one completed reply.
// Assumes rx_data holds the bytes after the status byte. Excess bytes beyond
// MAX_LEN are never examined.
module aux_rpl_classifier
    import aux_xact_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int CNT_W   = 5
) (
    input  aux_rx_flags_t         flags,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic [3:0]            rx_code,
    input  logic [MAX_LEN*8-1:0]  rx_data,
    input  logic [LEN_W-1:0]      req_len,
    output aux_result_e           result,
    output logic [3:0]            reply_code,
    output logic [CNT_W-1:0]      ret_count,
    output logic [MAX_LEN*8-1:0]  rd_data
);

    logic [CNT_W-1:0] data_cnt;
    logic             ack_data;

    // Priority classification: link loss, timeouts, framing errors, empty reply, overrun.
    always_comb begin
        data_cnt = rx_count - CNT_W'(1);
        if (flags.hpd_lost)
            result = RES_HPD;
        else if (flags.tmo || flags.tmo_state)
            result = RES_TIMEOUT;
        else if (flags.bad_stop || flags.no_detect || flags.bad_high || flags.bad_low)
            result = RES_INVALID;
        else if (rx_count == '0)
            result = RES_INVALID;
        else if ((rx_code == 4'h0) && (data_cnt > CNT_W'(req_len)))
            result = RES_OVERRUN;
        else
            result = RES_OK;
    end

    // Reported code, data count and data gating.
    always_comb begin
        reply_code = (result == RES_OK || result == RES_OVERRUN) ? rx_code : 4'h0;
        ret_count  = (result == RES_OK) ? data_cnt : '0;
        ack_data   = (result == RES_OK) && (rx_code == 4'h0);
    end

    // Data bytes pass only on ACK and only below the returned count.
    for (genvar q = 0; q < MAX_LEN; q++) begin : g_rd
        assign rd_data[q*8 +: 8] = (ack_data && (CNT_W'(q) < data_cnt)) ? rx_data[q*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/aux_xact_ctrl.sv
// Transaction sequencer: idle until a start, waits for reply completion,
// then issues a one-cycle done. Assumes start and rx_done are single-cycle
// strobes. Either strobe outside its own state is dropped.
module aux_xact_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rx_done,
    output logic load_req,
    output logic load_rpl,
    output logic busy,
    output logic done
);

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctrl_state_e;
    ctrl_state_e state;

    // Load enables for the request and reply registers.
    always_comb begin
        load_req = (state == ST_IDLE) && start;
        load_rpl = (state == ST_WAIT) && rx_done;
        busy     = (state == ST_WAIT);
    end

    // State and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            done <= load_rpl;
            if (load_req)
                state <= ST_WAIT;
            else if (load_rpl)
                state <= ST_IDLE;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R5
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy);
    // R13
    idle_reply_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && rx_done) |=> !done);

endmodule

// File: rtl/aux_xact_engine.sv
// Auxiliary-channel transaction engine top. It registers the framed request
// on an accepted start and the classified reply on a reply completion.
// Assumes the receive inputs are stable in the cycle rx_done is high.
module aux_xact_engine
    import aux_xact_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int TX_MAX = MAX_LEN + 4,
    localparam int CNT_W  = $clog2(TX_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [3:0]            cmd,
    input  logic [19:0]           addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [MAX_LEN*8-1:0]  wr_data,
    input  logic                  rx_done,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic [3:0]            rx_code,
    input  logic [MAX_LEN*8-1:0]  rx_data,
    input  logic                  rx_hpd_lost,
    input  logic                  rx_tmo,
    input  logic                  rx_tmo_state,
    input  logic                  rx_bad_stop,
    input  logic                  rx_no_detect,
    input  logic                  rx_bad_high,
    input  logic                  rx_bad_low,
    output logic                  busy,
    output logic [CNT_W-1:0]      tx_count,
    output logic [TX_MAX*8-1:0]   tx_bytes,
    output logic                  done,
    output logic [2:0]            result,
    output logic [3:0]            reply_code,
    output logic [CNT_W-1:0]      ret_count,
    output logic [MAX_LEN*8-1:0]  rd_data
);

    logic                 load_req, load_rpl;
    logic [TX_MAX*8-1:0]  frame_d;
    logic [CNT_W-1:0]     count_d;
    logic [LEN_W-1:0]     len_q;
    aux_rx_flags_t        flags;
    aux_result_e          res_d;
    logic [3:0]           code_d;
    logic [CNT_W-1:0]     ret_d;
    logic [MAX_LEN*8-1:0] rd_d;

    // Gather the receiver flags into one word.
    always_comb begin
        flags = '{hpd_lost: rx_hpd_lost, tmo: rx_tmo, tmo_state: rx_tmo_state,
                  bad_stop: rx_bad_stop, no_detect: rx_no_detect,
                  bad_high: rx_bad_high, bad_low: rx_bad_low};
    end

    aux_xact_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rx_done  (rx_done),
        .load_req (load_req),
        .load_rpl (load_rpl),
        .busy     (busy),
        .done     (done)
    );

    aux_req_framer #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .CNT_W   (CNT_W),
        .TX_MAX  (TX_MAX)
    ) u_framer (
        .cmd     (cmd),
        .addr    (addr),
        .len     (req_len),
        .wr_data (wr_data),
        .frame   (frame_d),
        .count   (count_d)
    );

    aux_rpl_classifier #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .CNT_W   (CNT_W)
    ) u_class (
        .flags      (flags),
        .rx_count   (rx_count),
        .rx_code    (rx_code),
        .rx_data    (rx_data),
        .req_len    (len_q),
        .result     (res_d),
        .reply_code (code_d),
        .ret_count  (ret_d),
        .rd_data    (rd_d)
    );

    // Request registers: loaded only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bytes <= '0;
            tx_count <= '0;
            len_q    <= '0;
        end else if (load_req) begin
            tx_bytes <= frame_d;
            tx_count <= count_d;
            len_q    <= req_len;
        end
    end

    // Reply registers: loaded only when a reply completes while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= 3'd0;
            reply_code <= 4'h0;
            ret_count  <= '0;
            rd_data    <= '0;
        end else if (load_rpl) begin
            result     <= res_d;
            reply_code <= code_d;
            ret_count  <= ret_d;
            rd_data    <= rd_d;
        end
    end

    // R4
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(tx_bytes) && $stable(tx_count)));
    // R6
    hpd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_done && rx_hpd_lost) |=> (done && result == 3'd1));
    // R8
    empty_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_done && rx_count == '0) |=> (result != 3'd0));
    // R9
    ok_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_done && !rx_hpd_lost && !rx_tmo && !rx_tmo_state && !rx_bad_stop &&
         !rx_no_detect && !rx_bad_high && !rx_bad_low && rx_count != '0 && rx_code != 4'h0)
        |=> (result == 3'd0 && ret_count == $past(rx_count) - CNT_W'(1)));

endmodule

// File: tb/aux_xact_engine_test.sv
module aux_xact_engine_test;

    localparam int ML  = 16;
    localparam int TXW = (ML + 4) * 8;
    localparam int DW  = ML * 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [3:0]     cmd = '0;
    logic [19:0]    addr = '0;
    logic [4:0]     req_len = '0;
    logic [DW-1:0]  wr_data = '0;
    logic           rx_done = 1'b0;
    logic [4:0]     rx_count = '0;
    logic [3:0]     rx_code = '0;
    logic [DW-1:0]  rx_data = '0;
    logic [6:0]     fl = '0;
    logic           busy, done;
    logic [4:0]     tx_count, ret_count;
    logic [TXW-1:0] tx_bytes;
    logic [2:0]     result;
    logic [3:0]     reply_code;
    logic [DW-1:0]  rd_data;

    int total = 0;
    int failed = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    aux_xact_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
        .req_len(req_len), .wr_data(wr_data), .rx_done(rx_done),
        .rx_count(rx_count), .rx_code(rx_code), .rx_data(rx_data),
        .rx_hpd_lost(fl[6]), .rx_tmo(fl[5]), .rx_tmo_state(fl[4]),
        .rx_bad_stop(fl[3]), .rx_no_detect(fl[2]), .rx_bad_high(fl[1]),
        .rx_bad_low(fl[0]),
        .busy(busy), .tx_count(tx_count), .tx_bytes(tx_bytes), .done(done),
        .result(result), .reply_code(reply_code), .ret_count(ret_count),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [TXW-1:0] act, input logic [TXW-1:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_wr(input logic [3:0] c);
        return (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
    endfunction

    function automatic logic [TXW-1:0] exp_frame(input logic [3:0] c, input logic [19:0] a,
                                                 input logic [4:0] l, input logic [DW-1:0] w);
        logic [TXW-1:0] f = '0;
        f[7:0]   = {c, a[19:16]};
        f[15:8]  = a[15:8];
        f[23:16] = a[7:0];
        if (l != 5'd0) f[31:24] = {3'b000, l} - 8'd1;
        if (is_wr(c))
            for (int i = 0; i < ML; i++)
                if (i < int'(l)) f[32 + i*8 +: 8] = w[i*8 +: 8];
        return f;
    endfunction

    function automatic logic [4:0] exp_count(input logic [3:0] c, input logic [4:0] l);
        logic [4:0] n = (l != 5'd0) ? 5'd4 : 5'd3;
        if (is_wr(c)) n = n + l;
        return n;
    endfunction

    function automatic logic [2:0] exp_res(input logic [6:0] f, input logic [4:0] n,
                                           input logic [3:0] c, input logic [4:0] l);
        if (f[6]) return 3'd1;
        if (f[5] || f[4]) return 3'd2;
        if (|f[3:0]) return 3'd3;
        if (n == 5'd0) return 3'd3;
        if (c == 4'h0 && (n - 5'd1) > l) return 3'd4;
        return 3'd0;
    endfunction

    // One full transaction with optional start poke while busy.
    task automatic run_one(input logic [3:0] c, input logic [19:0] a, input logic [4:0] l,
                           input logic [DW-1:0] w, input logic [6:0] f, input logic [4:0] n,
                           input logic [3:0] code, input logic [DW-1:0] rd, input bit poke);
        logic [TXW-1:0] ef;
        logic [2:0]     er;
        logic [DW-1:0]  ed;
        @(negedge clk);
        cmd = c; addr = a; req_len = l; wr_data = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ef = exp_frame(c, a, l, w);
        chk("R5 busy after start", TXW'(busy), TXW'(1'b1));
        chk("R1 R3 frame bytes", tx_bytes, ef);
        chk("R2 tx_count", TXW'(tx_count), TXW'(exp_count(c, l)));
        if (poke) begin
            cmd = ~c; addr = ~a; req_len = 5'd16; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R4 frame held under start", tx_bytes, ef);
            chk("R4 count held under start", TXW'(tx_count), TXW'(exp_count(c, l)));
            chk("R4 no done and still busy", TXW'({done, busy}), TXW'(2'b01));
        end
        fl = f; rx_count = n; rx_code = code; rx_data = rd; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; fl = '0;
        er = exp_res(f, n, code, l);
        ed = '0;
        if (er == 3'd0 && code == 4'h0)
            for (int j = 0; j < ML; j++)
                if (j < int'(n) - 1) ed[j*8 +: 8] = rd[j*8 +: 8];
        chk("R5 done pulse", TXW'({done, busy}), TXW'(2'b10));
        chk("R6 R7 R8 R11 result", TXW'(result), TXW'(er));
        chk("R9 R11 reply_code", TXW'(reply_code),
            TXW'((er == 3'd0 || er == 3'd4) ? code : 4'h0));
        chk("R9 ret_count", TXW'(ret_count), TXW'((er == 3'd0) ? n - 5'd1 : 5'd0));
        chk("R10 rd_data", TXW'(rd_data), TXW'(ed));
        @(negedge clk);
        chk("R5 done one cycle", TXW'(done), TXW'(1'b0));
    endtask

    function automatic logic [DW-1:0] rnd_bytes();
        logic [DW-1:0] v;
        for (int i = 0; i < ML / 4; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failed++; total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        logic [2:0]    sv_res;
        logic [4:0]    sv_ret;
        logic [DW-1:0] sv_rd;
        void'($urandom(32'h1d5c_07a3));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy/done", TXW'({busy, done}), TXW'(2'b00));
        chk("R12 tx_count", TXW'(tx_count), '0);
        chk("R12 tx_bytes", tx_bytes, '0);
        chk("R12 result/code/ret", TXW'({result, reply_code, ret_count}), '0);
        chk("R12 rd_data", TXW'(rd_data), '0);

        // Directed corners
        run_one(4'h9, 20'hA_BC12, 5'd0, '1, 7'b0, 5'd1, 4'h0, '0, 1'b0);           // R2 zero-length read
        run_one(4'h8, 20'h1_2345, 5'd16, rnd_bytes(), 7'b0, 5'd1, 4'h0, '0, 1'b1); // R3 full write, R4 poke
        run_one(4'h4, 20'hF_0001, 5'd3, rnd_bytes(), 7'b0, 5'd1, 4'h0, '0, 1'b0);  // R3 I2C write continuing
        run_one(4'h0, 20'h0_0050, 5'd0, rnd_bytes(), 7'b0, 5'd1, 4'h0, '0, 1'b0);  // R3 zero-length write
        run_one(4'h9, 20'h0_0200, 5'd4, '0, 7'b1111111, 5'd5, 4'h0, rnd_bytes(), 1'b0); // R6 priority
        run_one(4'h9, 20'h0_0200, 5'd4, '0, 7'b0011111, 5'd5, 4'h0, rnd_bytes(), 1'b0); // R7 over framing
        run_one(4'h9, 20'h0_0200, 5'd4, '0, 7'b0100000, 5'd5, 4'h0, rnd_bytes(), 1'b0); // R7 timeout alone
        run_one(4'h9, 20'h0_0200, 5'd4, '0, 7'b0000100, 5'd5, 4'h0, rnd_bytes(), 1'b0); // R8 no detect
        run_one(4'h9, 20'h0_0200, 5'd4, '0, 7'b0, 5'd0, 4'h0, rnd_bytes(), 1'b0);       // R8 empty reply
        run_one(4'h9, 20'h0_0300, 5'd4, '0, 7'b0, 5'd5, 4'h0, rnd_bytes(), 1'b0);       // R10 ACK full read
        run_one(4'h9, 20'h0_0300, 5'd4, '0, 7'b0, 5'd3, 4'h0, rnd_bytes(), 1'b0);       // R10 short read
        run_one(4'h9, 20'h0_0300, 5'd4, '0, 7'b0, 5'd3, 4'h1, rnd_bytes(), 1'b0);       // R9 R10 NACK
        run_one(4'h9, 20'h0_0300, 5'd2, '0, 7'b0, 5'd4, 4'h0, rnd_bytes(), 1'b0);       // R11 overrun
        run_one(4'h9, 20'h0_0300, 5'd16, '0, 7'b0, 5'd17, 4'h0, rnd_bytes(), 1'b0);     // R10 max read

        // R13: reply strobe while idle
        sv_res = result; sv_ret = ret_count; sv_rd = rd_data;
        @(negedge clk);
        rx_count = 5'd9; rx_code = 4'h2; fl = 7'b1000000; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; fl = '0;
        chk("R13 no done when idle", TXW'({done, busy}), TXW'(2'b00));
        chk("R13 outputs kept", TXW'({sv_res, sv_ret, sv_rd}), TXW'({result, ret_count, rd_data}));

        // Constrained random transactions
        for (int t = 0; t < 300; t++) begin
            logic [3:0]  c = 4'($urandom_range(0, 15));
            logic [4:0]  l = 5'($urandom_range(0, ML));
            logic [6:0]  f = '0;
            logic [4:0]  n;
            logic [3:0]  code = ($urandom_range(0, 1) == 0) ? 4'h0 : 4'($urandom_range(1, 15));
            for (int b = 0; b < 7; b++)
                if ($urandom_range(0, 9) == 0) f[b] = 1'b1;
            n = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, ML + 1))
                                            : 5'($urandom_range(1, int'(l) + 1));
            run_one(c, 20'($urandom()), l, rnd_bytes(), f, n, code, rnd_bytes(),
                    ($urandom_range(0, 4) == 0));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule